// File: doc/BRIEF.md
# Host-Link Serial Port with Hardware Flow Control

This block is an asynchronous serial port for carrying host traffic between a controller and its host. Bytes written by the local processor are queued in a 128-entry transmit queue and sent as 8N1 characters on the transmit pin. Bytes arriving on the receive pin are assembled with 16x oversampling and queued in a 128-entry receive queue that the processor reads through the same data register. Both queues have their own threshold interrupts.

Flow control is handled automatically in both directions. The transmitter starts a new character only while the clear-to-send input is high. The request-to-send output is pulled low when the receive queue fills to a programmable high-water mark. It is released once the queue drains below a low-water mark. Bytes that arrive after the request-to-send output has dropped are still accepted until the queue is full. The baud divisor resets to the value for 57600 baud at the default clock, and other rates from 300 to 921600 are reached by programming the divisor.

Top module: `hci_uart`

## Requirements
- R1: After reset, the divisor register (address 1, bits [15:0]) reads the default divisor CLK_HZ/(16*BAUD_DEF), which is 217 at the defaults. The status register (address 4) reads rx count 0 (bits [11:0]), tx count 0 (bits [23:12]), overrun 0 (bit 24), framing 0 (bit 25), busy 0 (bit 26) and rts 1 (bit 27). txd_o and rts_o are 1.
- R2: txd_oe is 0 at every clock edge while rst_n is low, and it is 1 after reset is released.
- R3: Each transmitted character is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts 16 × divisor clock cycles, and the line idles at 1.
- R4: No new character starts while cts_i is 0. A character already in progress when cts_i falls completes unchanged.
- R5: A received 8N1 character is stored in the receive queue and is returned in order by reads of address 0, bits [7:0]. Each read pops one byte.
- R6: A character whose stop bit is sampled 0 sets the sticky framing flag (status bit 25). A read of the status register clears the flag.
- R7: A character that arrives while the receive queue holds 128 bytes is discarded and sets the sticky overrun flag (status bit 24). The flag holds until the status register is read, and the queue contents are left unchanged.
- R8: rts_o goes to 0 once the rx count is at or above the high mark (address 3, bits [7:0]). It returns to 1 once the count is below the low mark (address 3, bits [23:16]). Bytes that arrive while rts_o is 0 are still stored.
- R9: irq_rx is 1 exactly when the rx count exceeds the receive threshold (address 2, bits [6:0], range 0 to 127).
- R10: irq_tx is 1 exactly when the tx count is at or below the transmit threshold (address 2, bits [23:16]). A written transmit threshold above 128 is stored as 128.
- R11: Each queue holds up to 128 bytes. A write to address 0 while the transmit queue is full is ignored, and the tx count stays at 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops rx data, clears sticky flags) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from address) |
| irq_rx | output | 1 | Receive threshold interrupt |
| irq_tx | output | 1 | Transmit threshold interrupt |
| txd_o | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit pin output enable |
| rxd_i | input | 1 | Serial receive data |
| cts_i | input | 1 | Clear to send, 1 permits a new character |
| rts_o | output | 1 | Request to send, 0 asks the far end to stop |

## Verification
The hardest state to reach from the ports is a completely full receive queue with request-to-send already low, followed by one more character. The bench streams 129 serial characters into the receiver without reading any of them. Along the way it checks the receive interrupt and the high-water transition. It then confirms that the 129th byte is lost and that the first 128 bytes read back in order, with request-to-send returning as the queue drains past the low mark. Stopping the transmitter in the middle of a character is reached by dropping clear-to-send a fixed number of cycles after it has been raised.

// File: rtl/hci_uart_pkg.sv
// Shared register addresses and engine state encodings for the host-link UART.
package hci_uart_pkg;
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_DIV  = 3'd1;
    localparam logic [2:0] A_THR  = 3'd2;
    localparam logic [2:0] A_FLOW = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/hci_uart_baud.sv
// Oversampling tick generator: one tick every 'div' clocks (div 0 acts as 1).
// Assumes the divisor is quasi-static; a new value takes effect at the next wrap.
module hci_uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count down and emit a single-cycle tick on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= (div == '0) ? '0 : div - 1'b1;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/hci_uart_fifo.sv
// Synchronous FIFO with occupancy count. Push when full and pop when empty are
// ignored; the caller decides what an ignored push means.
module hci_uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; no reset needed on the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping with explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hci_uart_tx.sv
// 8N1 transmit engine. Starts a character only on a tick with data queued and
// cts_ok high; once started the character runs to its stop bit regardless.
module hci_uart_tx
    import hci_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cts_ok,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       txd,
    output logic       busy
);
    tx_state_e  state;
    logic [3:0] ph;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       last_ph;

    assign last_ph = (ph == 4'd15);
    assign busy    = (state != TX_IDLE);
    assign q_pop   = (state == TX_IDLE) && tick && !q_empty && cts_ok;

    // Frame sequencer: 16 ticks per bit, LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            ph    <= '0;
            bitn  <= '0;
            shreg <= '0;
            txd   <= 1'b1;
        end else if (tick) begin
            ph <= ph + 1'b1;
            case (state)
                TX_IDLE: begin
                    ph <= '0;
                    if (q_pop) begin
                        shreg <= q_data;
                        txd   <= 1'b0;
                        state <= TX_START;
                    end
                end
                TX_START: if (last_ph) begin
                    txd   <= shreg[0];
                    bitn  <= '0;
                    state <= TX_DATA;
                end
                TX_DATA: if (last_ph) begin
                    if (bitn == 3'd7) begin
                        txd   <= 1'b1;
                        state <= TX_STOP;
                    end else begin
                        shreg <= {1'b0, shreg[7:1]};
                        txd   <= shreg[1];
                        bitn  <= bitn + 1'b1;
                    end
                end
                TX_STOP: if (last_ph) state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hci_uart_rx.sv
// 8N1 receive engine with 16x oversampling. A start is a high-to-low change
// between ticks, confirmed low at mid-bit; bits are sampled at their centres.
// Assumes rxd is already synchronised to clk.
module hci_uart_rx
    import hci_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] data,
    output logic       ferr
);
    rx_state_e  state;
    logic [3:0] ph;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       last;

    // Previous tick sample, for edge-qualified start detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    last <= 1'b1;
        else if (tick) last <= rxd;
    end

    // Bit sequencer: half-bit to start centre, then a full bit per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            ph    <= '0;
            bitn  <= '0;
            shreg <= '0;
            push  <= 1'b0;
            data  <= '0;
            ferr  <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                ph <= ph + 1'b1;
                case (state)
                    RX_IDLE: begin
                        ph <= '0;
                        if (last && !rxd) state <= RX_START;
                    end
                    RX_START: if (ph == 4'd7) begin
                        ph    <= '0;
                        bitn  <= '0;
                        state <= rxd ? RX_IDLE : RX_DATA;
                    end
                    RX_DATA: if (ph == 4'd15) begin
                        shreg <= {rxd, shreg[7:1]};
                        if (bitn == 3'd7) state <= RX_STOP;
                        bitn <= bitn + 1'b1;
                    end
                    RX_STOP: if (ph == 4'd15) begin
                        push  <= 1'b1;
                        data  <= shreg;
                        ferr  <= !rxd;
                        state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/hci_uart.sv
// Host-link UART top: register file, baud tick, transmit and receive queues,
// threshold interrupts and automatic RTS/CTS. Assumes queue depth fits the
// 12-bit count fields of the status word and single-cycle register strobes.
module hci_uart
    import hci_uart_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int BAUD_DEF    = 57600,
    parameter int FIFO_DEPTH  = 128,
    parameter int DIV_W       = 16,
    parameter int HI_MARK_DEF = 112,
    parameter int LO_MARK_DEF = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_rx,
    output logic        irq_tx,
    output logic        txd_o,
    output logic        txd_oe,
    input  logic        rxd_i,
    input  logic        cts_i,
    output logic        rts_o
);
    localparam int CW      = $clog2(FIFO_DEPTH + 1);
    localparam int DEF_DIV = CLK_HZ / (16 * BAUD_DEF);

    logic [DIV_W-1:0] div_q;
    logic [CW-2:0]    rx_thr_q;
    logic [CW-1:0]    tx_thr_q, hi_q, lo_q;
    logic [1:0]       rxd_s, cts_s;
    logic             cts_ok, tick;
    logic             ovr_q, ferr_q;

    logic             tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic [7:0]       tx_dout;
    logic [CW-1:0]    tx_cnt;
    logic             rx_pop, rx_full, rx_empty, rx_push, rx_ferr;
    logic [7:0]       rx_dout, rx_byte;
    logic [CW-1:0]    rx_cnt;
    logic             stat_rd;

    assign cts_ok  = cts_s[1];
    assign tx_push = reg_wr && (reg_addr == A_DATA);
    assign rx_pop  = reg_rd && (reg_addr == A_DATA);
    assign stat_rd = reg_rd && (reg_addr == A_STAT);
    assign irq_rx  = (rx_cnt > {1'b0, rx_thr_q});
    assign irq_tx  = (tx_cnt <= tx_thr_q);

    // Two-stage synchronisers for the asynchronous serial inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_s <= 2'b11;
            cts_s <= 2'b11;
        end else begin
            rxd_s <= {rxd_s[0], rxd_i};
            cts_s <= {cts_s[0], cts_i};
        end
    end

    // Keep the transmit pin released while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) txd_oe <= 1'b0;
        else        txd_oe <= 1'b1;
    end

    // Configuration registers; transmit threshold clamps at the queue depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= DIV_W'(DEF_DIV);
            rx_thr_q <= '0;
            tx_thr_q <= '0;
            hi_q     <= CW'(HI_MARK_DEF);
            lo_q     <= CW'(LO_MARK_DEF);
        end else if (reg_wr) begin
            case (reg_addr)
                A_DIV: div_q <= reg_wdata[DIV_W-1:0];
                A_THR: begin
                    rx_thr_q <= reg_wdata[CW-2:0];
                    tx_thr_q <= (reg_wdata[16 +: 8] > 8'(FIFO_DEPTH)) ?
                                CW'(FIFO_DEPTH) : CW'(reg_wdata[16 +: 8]);
                end
                A_FLOW: begin
                    hi_q <= reg_wdata[0 +: CW];
                    lo_q <= reg_wdata[16 +: CW];
                end
                default: ;
            endcase
        end
    end

    // Sticky receive error flags, cleared by a status read; new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q  <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            ovr_q  <= (ovr_q && !stat_rd) || (rx_push && rx_full);
            ferr_q <= (ferr_q && !stat_rd) || (rx_push && rx_ferr);
        end
    end

    // Receive flow control with hysteresis between the two water marks.
    always_ff @(posedge clk) begin
        if (!rst_n)               rts_o <= 1'b1;
        else if (rx_cnt >= hi_q)  rts_o <= 1'b0;
        else if (rx_cnt < lo_q)   rts_o <= 1'b1;
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA: if (!rx_empty) reg_rdata[7:0] = rx_dout;
            A_DIV:  reg_rdata[DIV_W-1:0] = div_q;
            A_THR: begin
                reg_rdata[CW-2:0]  = rx_thr_q;
                reg_rdata[16 +: CW] = tx_thr_q;
            end
            A_FLOW: begin
                reg_rdata[0 +: CW]  = hi_q;
                reg_rdata[16 +: CW] = lo_q;
            end
            A_STAT: begin
                reg_rdata[0 +: CW]  = rx_cnt;
                reg_rdata[12 +: CW] = tx_cnt;
                reg_rdata[24]       = ovr_q;
                reg_rdata[25]       = ferr_q;
                reg_rdata[26]       = tx_busy;
                reg_rdata[27]       = rts_o;
            end
            default: ;
        endcase
    end

    hci_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    hci_uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    hci_uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    hci_uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cts_ok(cts_ok), .q_empty(tx_empty),
        .q_data(tx_dout), .q_pop(tx_pop), .txd(txd_o), .busy(tx_busy)
    );

    hci_uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s[1]),
        .push(rx_push), .data(rx_byte), .ferr(rx_ferr)
    );
endmodule

// File: rtl/hci_uart_chk.sv
// Protocol checker for hci_uart, attached by bind. Observes queue counts,
// water marks, flow pins and the sticky overrun flag.
module hci_uart_chk #(
    parameter int DEPTH = 128,
    parameter int CW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] hi_q,
    input logic [CW-1:0] lo_q,
    input logic          rts_o,
    input logic          tx_busy,
    input logic          cts_ok,
    input logic          txd_o,
    input logic          ovr_q,
    input logic          stat_rd
);
    AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= hi_q) |=> !rts_o); // R8
    AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt < lo_q && rx_cnt < hi_q) |=> rts_o); // R8
    AST_TX_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(cts_ok)); // R4
    AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd_o); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH))); // R11
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !stat_rd) |=> ovr_q); // R7
endmodule

bind hci_uart hci_uart_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .hi_q(hi_q),
    .lo_q(lo_q), .rts_o(rts_o), .tx_busy(tx_busy), .cts_ok(cts_ok),
    .txd_o(txd_o), .ovr_q(ovr_q), .stat_rd(stat_rd)
);

// File: tb/hci_uart_bench.sv
`timescale 1ns/1ps
module hci_uart_bench;
    localparam int BP = 16; // bit period in clocks with divisor 1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_rx, irq_tx, txd_o, txd_oe, rts_o;
    logic        rxd_i = 1'b1, cts_i = 1'b1;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    hci_uart u_hci_uart (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .txd_o(txd_o), .txd_oe(txd_oe), .rxd_i(rxd_i), .cts_i(cts_i), .rts_o(rts_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopv);
        rxd_i = 1'b0; repeat (BP) @(negedge clk);
        for (int k = 0; k < 8; k++) begin rxd_i = b[k]; repeat (BP) @(negedge clk); end
        rxd_i = stopv; repeat (BP) @(negedge clk);
        rxd_i = 1'b1; repeat (24) @(negedge clk);
    endtask

    task automatic cap_tx(output logic [7:0] b, output logic sb, output logic found);
        found = 1'b0; b = '0; sb = 1'b0;
        for (int i = 0; i < 2000 && !found; i++) begin
            @(negedge clk);
            if (txd_o === 1'b0) found = 1'b1;
        end
        if (found) begin
            repeat (8) @(negedge clk);
            for (int k = 0; k < 8; k++) begin repeat (BP) @(negedge clk); b[k] = txd_o; end
            repeat (BP) @(negedge clk);
            sb = txd_o;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        repeat (5) @(negedge clk);
        chk("R2 oe during reset", 32'(txd_oe), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 oe after reset", 32'(txd_oe), 32'd1);
        chk("R1 txd idle", 32'(txd_o), 32'd1);
        chk("R1 rts", 32'(rts_o), 32'd1);
        rd(A_DIV_B, d);
        chk("R1 divisor", d, 32'd217);
        rd(A_STAT_B, d);
        chk("R1 status", d, 32'h0800_0000);
    endtask

    localparam logic [2:0] A_DATA_B = 3'd0, A_DIV_B = 3'd1, A_THR_B = 3'd2,
                           A_FLOW_B = 3'd3, A_STAT_B = 3'd4;

    task automatic t_tx_frame();
        logic [7:0] b; logic sb, f;
        wr(A_DIV_B, 32'd1);
        wr(A_DATA_B, 32'hA5);
        cap_tx(b, sb, f);
        chk("R3 found start", 32'(f), 32'd1);
        chk("R3 byte A5", 32'(b), 32'hA5);
        chk("R3 stop bit", 32'(sb), 32'd1);
        wr(A_DATA_B, 32'h3C);
        cap_tx(b, sb, f);
        chk("R3 byte 3C", 32'(b), 32'h3C);
        chk("R3 stop bit 2", 32'(sb), 32'd1);
        repeat (20) @(negedge clk);
        chk("R10 irq_tx empty", 32'(irq_tx), 32'd1);
    endtask

    task automatic t_cts();
        logic [7:0] b; logic sb, f; logic [31:0] d; int lows;
        cts_i = 1'b0;
        repeat (4) @(negedge clk);
        wr(A_DATA_B, 32'h81);
        wr(A_DATA_B, 32'h7E);
        lows = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd_o !== 1'b1) lows++; end
        chk("R4 held by cts", 32'(lows), 32'd0);
        rd(A_STAT_B, d);
        chk("R4 tx count 2", 32'(d[23:12]), 32'd2);
        fork
            cap_tx(b, sb, f);
            begin cts_i = 1'b1; repeat (40) @(negedge clk); cts_i = 1'b0; end
        join
        chk("R4 in-flight completes", 32'(b), 32'h81);
        chk("R4 in-flight stop", 32'(sb), 32'd1);
        lows = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd_o !== 1'b1) lows++; end
        chk("R4 next held", 32'(lows), 32'd0);
        rd(A_STAT_B, d);
        chk("R4 tx count 1", 32'(d[23:12]), 32'd1);
        cts_i = 1'b1;
        cap_tx(b, sb, f);
        chk("R4 resumes", 32'(b), 32'h7E);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        send_rx(8'h5A, 1'b1);
        chk("R9 irq_rx one byte", 32'(irq_rx), 32'd1);
        send_rx(8'hC3, 1'b1);
        rd(A_STAT_B, d);
        chk("R5 rx count", 32'(d[11:0]), 32'd2);
        rd(A_DATA_B, d);
        chk("R5 first byte", d, 32'h5A);
        rd(A_DATA_B, d);
        chk("R5 second byte", d, 32'hC3);
        chk("R9 irq_rx empty", 32'(irq_rx), 32'd0);
    endtask

    task automatic t_ferr();
        logic [31:0] d;
        send_rx(8'h96, 1'b0);
        rd(A_STAT_B, d);
        chk("R6 framing flag set", 32'(d[25]), 32'd1);
        rd(A_STAT_B, d);
        chk("R6 framing flag cleared", 32'(d[25]), 32'd0);
        rd(A_DATA_B, d);
        send_rx(8'h11, 1'b1);
        rd(A_STAT_B, d);
        chk("R6 good byte no flag", 32'(d[25]), 32'd0);
        rd(A_DATA_B, d);
        chk("R6 next byte intact", d, 32'h11);
    endtask

    task automatic t_flow_overrun();
        logic [31:0] d; int bad;
        wr(A_THR_B, 32'd10);
        wr(A_FLOW_B, (32'd50 << 16) | 32'd100);
        for (int i = 0; i < 129; i++) begin
            send_rx((i == 128) ? 8'hEE : (8'(i) ^ 8'h3C), 1'b1);
            if (i == 9)  chk("R9 irq_rx at thr", 32'(irq_rx), 32'd0);
            if (i == 10) chk("R9 irq_rx above thr", 32'(irq_rx), 32'd1);
            if (i == 98) chk("R8 rts below high", 32'(rts_o), 32'd1);
            if (i == 99) chk("R8 rts at high", 32'(rts_o), 32'd0);
            if (i == 127) begin
                rd(A_STAT_B, d);
                chk("R8 accepted after rts low", 32'(d[11:0]), 32'd128);
                chk("R11 rx full no overrun", 32'(d[24]), 32'd0);
            end
        end
        rd(A_STAT_B, d);
        chk("R7 count unchanged", 32'(d[11:0]), 32'd128);
        chk("R7 overrun set", 32'(d[24]), 32'd1);
        rd(A_STAT_B, d);
        chk("R7 overrun cleared", 32'(d[24]), 32'd0);
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            rd(A_DATA_B, d);
            if (d !== 32'(8'(i) ^ 8'h3C)) bad++;
            @(negedge clk);
            if (i == 77) chk("R8 rts held at low mark", 32'(rts_o), 32'd0);
            if (i == 78) chk("R8 rts released below low", 32'(rts_o), 32'd1);
        end
        chk("R7 contents preserved", 32'(bad), 32'd0);
        wr(A_THR_B, 32'd0);
    endtask

    task automatic t_tx_thr_full();
        logic [31:0] d;
        cts_i = 1'b0;
        repeat (4) @(negedge clk);
        wr(A_THR_B, 32'd200 << 16);
        rd(A_THR_B, d);
        chk("R10 threshold clamp", 32'(d[23:16]), 32'd128);
        wr(A_THR_B, 32'd4 << 16);
        chk("R10 irq_tx empty", 32'(irq_tx), 32'd1);
        for (int i = 0; i < 4; i++) wr(A_DATA_B, 32'(i));
        chk("R10 irq_tx at thr", 32'(irq_tx), 32'd1);
        wr(A_DATA_B, 32'd4);
        chk("R10 irq_tx above thr", 32'(irq_tx), 32'd0);
        for (int i = 5; i < 130; i++) wr(A_DATA_B, 32'(i));
        rd(A_STAT_B, d);
        chk("R11 tx count capped", 32'(d[23:12]), 32'd128);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_tx_frame();
        t_cts();
        t_rx();
        t_ferr();
        t_flow_overrun();
        t_tx_thr_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule